// File: doc/BRIEF.md
# Hierarchical Carry Lookahead Adder

This block is a purely combinational binary adder for operands whose width is a multiple of four. It is built from 4-bit lookahead groups. Each group forms a generate term (`a & b`) and a propagate term (`a ^ b`) for every bit. It then computes the three carries inside the group as flattened two-level sums of products of those terms and the group's incoming carry. Each sum bit is the propagate term of that bit XOR the carry into that bit. Bit 0 is the least significant bit.

The parameter `TWO_LEVEL` selects how carries cross group boundaries:

- **Ripple mode (`TWO_LEVEL = 0`).** Each group computes its own outgoing carry with the full four-term equation. That carry enters the next group.
- **Group mode (`TWO_LEVEL = 1`).** Each group exports a group generate and a group propagate. A second-level lookahead unit applies the same four-term equations across sets of four groups. Sets of four groups pass their carry from one set to the next.

The block has no clock. It is meant to sit between registers in a datapath.

Top module: `cla_adder`

## Requirements
- R1: The parameter `W` sets the operand width. It must be a multiple of 4 and at least 4, and defaults to 16. Any other value stops elaboration with an error.
- R2: For every input combination, `{cout, sum}` equals `a + b + cin` computed in W+1 bits, with bit 0 of each vector being the least significant.
- R3: When every bit pair differs (`b == ~a`), the incoming carry runs through the whole adder: `cout == cin` and every bit of `sum` equals `~cin`.
- R4: With both operands zero, `sum` equals `cin` in bit 0 and zero above it, and `cout` is 0.
- R5: A 4-bit group never raises both group generate and group propagate. A carry generated in the lowest group reaches `cout` through higher groups whose bit pairs all differ: for W=16, `a=0x0008`, `b=0xFFF8`, `cin=0` gives `sum=0x0000` and `cout=1`.
- R6: With `TWO_LEVEL=1`, the carry into each group k+1 equals group generate of group k OR (group propagate of group k AND the carry into group k). This also holds when the number of groups needs more than one second-level set (W=24).
- R7: Both carry modes give identical `sum` and `cout` for identical inputs.
- R8: A carry generated only by the most significant bit pair appears at `cout`: with `a` and `b` both equal to `1 << (W-1)`, `cout=1` and `sum` equals `cin` in bit 0 and zero above it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | W | First operand, bit 0 least significant |
| b | input | W | Second operand, bit 0 least significant |
| cin | input | 1 | Carry into bit 0 |
| sum | output | W | Low W bits of a + b + cin |
| cout | output | 1 | Carry out of bit W-1 |

## Verification
The bound checker evaluates these on every input change:

- the arithmetic identity of R2;
- the full-propagate case of R3;
- the zero-operand case of R4;
- that no group ever reports both generate and propagate;
- in group mode, that each group-boundary carry produced by the second-level unit agrees with the group's own generate, propagate and incoming carry.

Only the bench's scenarios can show the rest. It sweeps every 8-bit operand pair with both carry-in values in both modes. It compares the two modes against each other. It exercises a width that needs two second-level sets. It drives the directed corner patterns that steer a carry from the lowest group or from the top bit pair to `cout`.

// File: rtl/cla_adder.sv
module cla_adder #(
  parameter int W         = 16,
  parameter bit TWO_LEVEL = 1'b0
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  localparam int NG = W / 4;
  localparam int NS = (NG + 3) / 4;

  // carries 1..3 inside one group, flattened two-level form
  function automatic logic [3:1] inner3(input logic [3:0] g, input logic [3:0] p, input logic c0);
    inner3[1] = g[0] | (p[0] & c0);
    inner3[2] = g[1] | (p[1] & g[0]) | (p[1] & p[0] & c0);
    inner3[3] = g[2] | (p[2] & g[1]) | (p[2] & p[1] & g[0]) | (p[2] & p[1] & p[0] & c0);
  endfunction

  function automatic logic [4:1] full4(input logic [3:0] g, input logic [3:0] p, input logic c0);
    full4[3:1] = inner3(g, p, c0);
    full4[4]   = g[3] | (p[3] & g[2]) | (p[3] & p[2] & g[1]) | (p[3] & p[2] & p[1] & g[0])
               | (p[3] & p[2] & p[1] & p[0] & c0);
  endfunction

  function automatic logic grp_gen(input logic [3:0] g, input logic [3:0] p);
    grp_gen = g[3] | (p[3] & g[2]) | (p[3] & p[2] & g[1]) | (p[3] & p[2] & p[1] & g[0]);
  endfunction

  if ((W % 4) != 0 || W < 4) begin : g_bad_width
    $error("cla_adder: W must be a positive multiple of 4");
  end

  logic [W-1:0]  g, p, c;
  logic [NG-1:0] grp_g, grp_p;
  logic [NG:0]   gc;

  assign g     = a & b;
  assign p     = a ^ b;
  assign sum   = p ^ c;
  assign gc[0] = cin;
  assign cout  = gc[NG];

  for (genvar k = 0; k < NG; k++) begin : g_grp
    assign c[4*k]             = gc[k];
    assign c[4*k+3:4*k+1]     = inner3(g[4*k +: 4], p[4*k +: 4], gc[k]);
    assign grp_g[k]           = grp_gen(g[4*k +: 4], p[4*k +: 4]);
    assign grp_p[k]           = &p[4*k +: 4];
  end

  if (!TWO_LEVEL) begin : g_ripple
    for (genvar k = 0; k < NG; k++) begin : g_link
      assign gc[k+1] = grp_g[k] | (grp_p[k] & gc[k]);
    end
  end else begin : g_second
    logic [4*NS-1:0] sg, sp;
    logic [NS-1:0]   sc;
    assign sc[0] = cin;
    for (genvar i = 0; i < 4*NS; i++) begin : g_pad
      if (i < NG) begin : g_real
        assign sg[i] = grp_g[i];
        assign sp[i] = grp_p[i];
      end else begin : g_fill
        assign sg[i] = 1'b0;
        assign sp[i] = 1'b1;
      end
    end
    for (genvar s = 0; s < NS; s++) begin : g_set
      logic [4:1] cs;
      assign cs = full4(sg[4*s +: 4], sp[4*s +: 4], sc[s]);
      if (s < NS - 1) begin : g_next
        assign sc[s+1] = cs[4];
      end
      for (genvar j = 0; j < 4; j++) begin : g_out
        if (4*s + j + 1 <= NG) begin : g_use
          assign gc[4*s+j+1] = cs[j+1];
        end
      end
    end
  end
endmodule

module cla_adder_chk #(
  parameter int W         = 16,
  parameter bit TWO_LEVEL = 1'b0,
  parameter int NG        = W / 4
) (
  input logic [W-1:0]  a,
  input logic [W-1:0]  b,
  input logic          cin,
  input logic [W-1:0]  sum,
  input logic          cout,
  input logic [NG-1:0] grp_g,
  input logic [NG-1:0] grp_p,
  input logic [NG:0]   gc
);
  logic [W:0] total;
  assign total = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};

  always_comb begin
    // R2
    sum_value_chk: assert ({cout, sum} == total);
    // R3
    if (b == ~a) begin
      full_prop_chk: assert (cout == cin && sum == {W{~cin}});
    end
    // R4
    if (a == '0 && b == '0) begin
      zero_ops_chk: assert (!cout && sum == {{(W-1){1'b0}}, cin});
    end
    for (int k = 0; k < NG; k++) begin
      // R5
      gp_excl_chk: assert (!(grp_g[k] && grp_p[k]));
      if (TWO_LEVEL) begin
        // R6
        second_level_chk: assert (gc[k+1] == (grp_g[k] | (grp_p[k] & gc[k])));
      end
    end
  end
endmodule

bind cla_adder cla_adder_chk #(.W(W), .TWO_LEVEL(TWO_LEVEL)) u_chk (
  .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout),
  .grp_g(grp_g), .grp_p(grp_p), .gc(gc)
);

// File: tb/cla_adder_bench.sv
`timescale 1ns/1ps
module cla_adder_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [15:0] a16, b16;  logic c16;
  logic [15:0] sr16, sg16; logic cr16, cg16;
  logic [7:0]  a8, b8;    logic c8;
  logic [7:0]  sr8, sg8;  logic cr8, cg8;
  logic [23:0] a24, b24;  logic c24;
  logic [23:0] s24;       logic co24;

  cla_adder #(.W(16), .TWO_LEVEL(1'b0)) u_cla_adder     (.a(a16), .b(b16), .cin(c16), .sum(sr16), .cout(cr16));
  cla_adder #(.W(16), .TWO_LEVEL(1'b1)) u_cla_adder_g16 (.a(a16), .b(b16), .cin(c16), .sum(sg16), .cout(cg16));
  cla_adder #(.W(8),  .TWO_LEVEL(1'b0)) u_cla_adder_r8  (.a(a8),  .b(b8),  .cin(c8),  .sum(sr8),  .cout(cr8));
  cla_adder #(.W(8),  .TWO_LEVEL(1'b1)) u_cla_adder_g8  (.a(a8),  .b(b8),  .cin(c8),  .sum(sg8),  .cout(cg8));
  cla_adder #(.W(24), .TWO_LEVEL(1'b1)) u_cla_adder_g24 (.a(a24), .b(b24), .cin(c24), .sum(s24),  .cout(co24));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run16(input logic [15:0] x, input logic [15:0] y, input logic ci, input string req);
    logic [16:0] e;
    @(posedge clk); #1;
    a16 = x; b16 = y; c16 = ci;
    e = {1'b0, x} + {1'b0, y} + {16'd0, ci};
    @(negedge clk);
    chk({cr16, sr16} == e, req, {15'd0, cr16, sr16}, {15'd0, e});
    chk({cg16, sg16} == e, req, {15'd0, cg16, sg16}, {15'd0, e});
    // R7
    chk({cr16, sr16} == {cg16, sg16}, "R7", {15'd0, cr16, sr16}, {15'd0, cg16, sg16});
  endtask

  initial begin
    a16 = '0; b16 = '0; c16 = 1'b0;
    a8 = '0; b8 = '0; c8 = 1'b0;
    a24 = '0; b24 = '0; c24 = 1'b0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R4 reset-time state: zero operands give zero result
    chk(sr16 == 16'd0 && !cr16, "R4", {15'd0, cr16, sr16}, 32'd0);
    run16(16'h0000, 16'h0000, 1'b1, "R4");
    run16(16'h1234, 16'hEDCB, 1'b0, "R3");
    run16(16'h1234, 16'hEDCB, 1'b1, "R3");
    run16(16'hFFFF, 16'h0000, 1'b1, "R3");
    run16(16'h0008, 16'hFFF8, 1'b0, "R5");
    run16(16'h8000, 16'h8000, 1'b0, "R8");
    run16(16'h8000, 16'h8000, 1'b1, "R8");
    run16(16'hAAAA, 16'h5556, 1'b0, "R2");
    run16(16'hFFFF, 16'hFFFF, 1'b1, "R2");
    run16(16'h0F0F, 16'h00F1, 1'b0, "R6");
    // R1 R2 R6 R7: exhaustive 8-bit sweep, both modes
    for (int x = 0; x < 256; x++) begin
      for (int y = 0; y < 256; y++) begin
        for (int ci = 0; ci < 2; ci++) begin
          logic [8:0] e;
          @(posedge clk); #1;
          a8 = x[7:0]; b8 = y[7:0]; c8 = ci[0];
          e = {1'b0, x[7:0]} + {1'b0, y[7:0]} + {8'd0, ci[0]};
          @(negedge clk);
          chk({cr8, sr8} == e, "R2", {23'd0, cr8, sr8}, {23'd0, e});
          chk({cg8, sg8} == e, "R6", {23'd0, cg8, sg8}, {23'd0, e});
        end
      end
    end
    // R2 R7 random 16-bit
    for (int n = 0; n < 6000; n++) begin
      run16(16'($urandom), 16'($urandom), 1'($urandom), "R2");
    end
    // R6 two second-level sets at W=24, random and corners
    for (int n = 0; n < 4000; n++) begin
      logic [24:0] e;
      logic [23:0] x, y;
      logic ci;
      x = 24'($urandom); y = 24'($urandom); ci = 1'($urandom);
      if (n == 0) begin x = 24'hFFFFFF; y = 24'h000000; ci = 1'b1; end
      if (n == 1) begin x = 24'h000008; y = 24'hFFFFF8; ci = 1'b0; end
      @(posedge clk); #1;
      a24 = x; b24 = y; c24 = ci;
      e = {1'b0, x} + {1'b0, y} + {24'd0, ci};
      @(negedge clk);
      chk({co24, s24} == e, "R6", {7'd0, co24, s24}, {7'd0, e});
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule